// File: doc/BRIEF.md
# Tower-Field GF(4096) Multiplier

This block multiplies two 12-bit elements of GF(4096). The field is built as a quadratic extension of GF(64). Each operand is cut into a 6-bit upper half and a 6-bit lower half. Four GF(64) products are combined with XOR to form the two halves of the result. The subfield is reduced by x^6+x+1. The extension polynomial adds one constant multiply by 0x21, which is applied to the product of the upper halves.

A valid strobe travels with each operand pair. By default a single output register gives a fixed latency of one cycle, and a parameter can remove that register so the path is purely combinational. A generator mode computes the step used to build code generators: it ignores the second operand, maps 0 to 1, and multiplies any other input by the fixed element 0xE01. A typical use is a Reed-Solomon encoder or syndrome unit that needs one field multiply per cycle.

Top module: `gf4096_mul`

## Requirements
- R1: GF(64) products use the polynomial x^6+x+1. For example, 0x002 times 0x020 (x times x^5 in the lower half) gives 0x003.
- R2: Operand bits 11..6 form the upper half and bits 5..0 the lower half. Result bits 11..6 equal (ah^al)*(bh^bl) XOR al*bl, with the products taken in GF(64).
- R3: Result bits 5..0 equal ((ah*bh)*0x21) XOR al*bl. Examples: 0x040*0x040 = 0x061 and 0x080*0x080 = 0x102.
- R4: In multiply mode, a zero in either operand gives a zero result.
- R5: In multiply mode, 0x001 is the identity from either side.
- R6: Multiplication is commutative: swapping op_a and op_b gives the same result.
- R7: With gen_mode=1, op_b is ignored. An op_a of 0 gives 0x001, and any other op_a gives op_a*0xE01 (so 0x001 gives 0xE01).
- R8: With the default PIPE=1, out_valid and result follow an in_valid=1 cycle by exactly one clock edge. With PIPE=0 they are combinational.
- R9: When in_valid is 0, out_valid falls after the next edge and result keeps its last value, whatever the operands do.
- R10: While rst_n is low, out_valid and result are 0, asynchronously. Release of the reset is synchronised inside the block over two clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| gen_mode | input | 1 | 1 selects the generator step, 0 selects a plain multiply |
| op_a | input | 12 | First operand, or the generator input |
| op_b | input | 12 | Second operand, ignored in generator mode |
| out_valid | output | 1 | Result valid |
| result | output | 12 | Field product |

## Verification
The only state is the output register and the reset synchroniser. A wrong enable or a stale value shows as a result that does not match one cycle after the operands were applied, or as a result that changes during an idle cycle. A fault in a subfield product or in the constant multiply leaves no sign in the state. It shows on the very next output as a wrong half of the word. The hand-worked vectors that isolate each half, together with commutativity and the generator constant, point to the part of the logic that failed.

// File: rtl/gf4096_pkg.sv
package gf4096_pkg;
  localparam int          DEF_SUB_W = 6;
  localparam logic [6:0]  DEF_SUB_POLY = 7'h43;
  localparam logic [5:0]  DEF_EXT_K = 6'h21;
  localparam logic [11:0] DEF_GEN_K = 12'hE01;

  typedef enum logic {
    MODE_MUL = 1'b0,
    MODE_GEN = 1'b1
  } op_mode_e;
endpackage

// File: rtl/gf_sub_mul.sv
module gf_sub_mul #(
  parameter int          W    = 6,
  parameter logic [W:0]  POLY = 7'h43
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);
  logic [W-1:0] acc [0:W];
  logic [W-1:0] sh  [0:W-1];

  assign acc[0] = '0;
  assign sh[0]  = b;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign acc[i+1] = acc[i] ^ (a[i] ? sh[i] : '0);
    if (i < W - 1) begin : g_shift
      logic [W:0] shx;
      assign shx = {sh[i], 1'b0};
      assign sh[i+1] = shx[W] ? (shx[W-1:0] ^ POLY[W-1:0]) : shx[W-1:0];
    end
  end

  assign p = acc[W];
endmodule

// File: rtl/gf_tower_mul.sv
module gf_tower_mul #(
  parameter int               SUB_W    = 6,
  parameter logic [SUB_W:0]   SUB_POLY = 7'h43,
  parameter logic [SUB_W-1:0] EXT_K    = 6'h21,
  localparam int              W        = 2 * SUB_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);
  logic [SUB_W-1:0] ah, al, bh, bl;
  logic [SUB_W-1:0] p_sum, p_lo, p_hi, p_ext;

  assign {ah, al} = a;
  assign {bh, bl} = b;

  gf_sub_mul #(.W(SUB_W), .POLY(SUB_POLY)) u_sum (
    .a(ah ^ al), .b(bh ^ bl), .p(p_sum));
  gf_sub_mul #(.W(SUB_W), .POLY(SUB_POLY)) u_lo (
    .a(al), .b(bl), .p(p_lo));
  gf_sub_mul #(.W(SUB_W), .POLY(SUB_POLY)) u_hi (
    .a(ah), .b(bh), .p(p_hi));
  gf_sub_mul #(.W(SUB_W), .POLY(SUB_POLY)) u_ext (
    .a(p_hi), .b(EXT_K), .p(p_ext));

  assign p = {p_sum ^ p_lo, p_ext ^ p_lo};
endmodule

// File: rtl/gf_out_stage.sv
module gf_out_stage #(
  parameter int W    = 12,
  parameter bit PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);
  if (PIPE) begin : g_reg
    logic         vld_q, vld_d;
    logic [W-1:0] dat_q, dat_d;

    always_comb begin
      vld_d = vld_i;
      dat_d = vld_i ? dat_i : dat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else begin
        vld_q <= vld_d;
        dat_q <= dat_d;
      end
    end

    assign vld_o = vld_q;
    assign dat_o = dat_q;
  end else begin : g_wire
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign vld_o = vld_i;
    assign dat_o = dat_i;
  end
endmodule

// File: rtl/gf_rst_sync.sv
module gf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/gf4096_mul.sv
module gf4096_mul
  import gf4096_pkg::*;
#(
  parameter int                 SUB_W    = DEF_SUB_W,
  parameter logic [SUB_W:0]     SUB_POLY = DEF_SUB_POLY,
  parameter logic [SUB_W-1:0]   EXT_K    = DEF_EXT_K,
  parameter logic [2*SUB_W-1:0] GEN_K    = DEF_GEN_K,
  parameter bit                 PIPE     = 1'b1,
  localparam int                W        = 2 * SUB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         gen_mode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         out_valid,
  output logic [W-1:0] result
);
  localparam logic [W-1:0] ONE = W'(1);

  op_mode_e     mode;
  logic         rst_q_n;
  logic [W-1:0] mul_b;
  logic [W-1:0] prod;
  logic [W-1:0] sel;

  assign mode = op_mode_e'(gen_mode);

  gf_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  always_comb begin
    mul_b = (mode == MODE_GEN) ? GEN_K : op_b;
  end

  gf_tower_mul #(.SUB_W(SUB_W), .SUB_POLY(SUB_POLY), .EXT_K(EXT_K)) u_core (
    .a(op_a), .b(mul_b), .p(prod));

  always_comb begin
    if (mode == MODE_GEN && op_a == '0) sel = ONE;
    else                                sel = prod;
  end

  gf_out_stage #(.W(W), .PIPE(PIPE)) u_out (
    .clk(clk), .rst_n(rst_q_n),
    .vld_i(in_valid), .dat_i(sel),
    .vld_o(out_valid), .dat_o(result));
endmodule

// File: rtl/gf4096_mul_chk.sv
module gf4096_mul_chk #(
  parameter int         W     = 12,
  parameter logic [W-1:0] GEN_K = 12'hE01,
  parameter bit         PIPE  = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         gen_mode,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         out_valid,
  input logic [W-1:0] result
);
  if (PIPE) begin : g_chk
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R8
    AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result)); // R9
    AST_ZERO_ANNIH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !gen_mode && (op_a == '0 || op_b == '0)) |=> result == '0); // R4
    AST_UNIT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !gen_mode && op_a == W'(1)) |=> result == $past(op_b)); // R5
    AST_GEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && gen_mode && op_a == '0) |=> result == W'(1)); // R7
    AST_GEN_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && gen_mode && op_a == W'(1)) |=> result == GEN_K); // R7
  end
endmodule

bind gf4096_mul gf4096_mul_chk #(.W(W), .GEN_K(GEN_K), .PIPE(PIPE)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .in_valid(in_valid), .gen_mode(gen_mode),
  .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result));

// File: tb/tb_gf4096_mul.sv
module tb_gf4096_mul;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, gen_mode;
  logic [11:0] op_a, op_b;
  logic        out_valid;
  logic [11:0] result;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  gf4096_mul dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .gen_mode(gen_mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result));

  // {gen, a, b, expected}: hand-worked products
  localparam logic [36:0] VEC [0:11] = '{
    {1'b0, 12'h001, 12'hABC, 12'hABC},  // R5
    {1'b0, 12'hABC, 12'h001, 12'hABC},  // R5
    {1'b0, 12'h000, 12'hFFF, 12'h000},  // R4
    {1'b0, 12'h5A5, 12'h000, 12'h000},  // R4
    {1'b0, 12'h040, 12'h040, 12'h061},  // R3
    {1'b0, 12'h080, 12'h080, 12'h102},  // R3
    {1'b0, 12'h040, 12'h001, 12'h040},  // R2
    {1'b0, 12'h002, 12'h020, 12'h003},  // R1
    {1'b0, 12'h020, 12'h002, 12'h003},  // R1 R6
    {1'b1, 12'h000, 12'h123, 12'h001},  // R7
    {1'b1, 12'h001, 12'h777, 12'hE01},  // R7
    {1'b1, 12'h001, 12'h000, 12'hE01}   // R7
  };

  // reference: carry-less product then long-division reduction
  function automatic logic [5:0] ref64(input logic [5:0] a, input logic [5:0] b);
    logic [10:0] t = '0;
    for (int i = 0; i < 6; i++) if (a[i]) t ^= 11'(b) << i;
    for (int k = 10; k >= 6; k--) if (t[k]) t ^= 11'h43 << (k - 6);
    return t[5:0];
  endfunction

  function automatic logic [11:0] ref12(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] lo, hi;
    lo = ref64(a[5:0], b[5:0]);
    hi = ref64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ lo;
    return {hi, ref64(ref64(a[11:6], b[11:6]), 6'h21) ^ lo};
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic g, input logic [11:0] a, input logic [11:0] b,
                       input logic [11:0] exp, input string req);
    in_valid = 1'b1; gen_mode = g; op_a = a; op_b = b;
    @(negedge clk);
    check({req, " R8 valid"}, {11'd0, out_valid}, 12'd1);
    check(req, result, exp);
  endtask

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] ra, rb, r1, keep;
    rst_n = 1'b0; in_valid = 1'b0; gen_mode = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    check("R10 reset valid", {11'd0, out_valid}, 12'd0);
    check("R10 reset result", result, 12'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 12; i++)
      apply(VEC[i][36], VEC[i][35:24], VEC[i][23:12], VEC[i][11:0], "R1-table");

    for (int i = 0; i < 150; i++) begin
      ra = 12'($urandom); rb = 12'($urandom);
      apply(1'b0, ra, rb, ref12(ra, rb), "R2 R3 random");
      r1 = result;
      apply(1'b0, rb, ra, r1, "R6 commute");
      apply(1'b1, ra, rb, (ra == 0) ? 12'h001 : ref12(ra, 12'hE01), "R7 random gen");
    end

    // R7: op_b has no effect in generator mode
    apply(1'b1, 12'h0AB, 12'h123, ref12(12'h0AB, 12'hE01), "R7 gen b1");
    apply(1'b1, 12'h0AB, 12'hFFF, ref12(12'h0AB, 12'hE01), "R7 gen b2");

    // R9: idle cycles hold the result
    keep = result;
    in_valid = 1'b0; op_a = 12'h3C3; op_b = 12'h5A5;
    @(negedge clk);
    check("R9 idle valid", {11'd0, out_valid}, 12'd0);
    check("R9 idle hold", result, keep);
    op_a = 12'h001; op_b = 12'h777;
    @(negedge clk);
    check("R9 idle hold 2", result, keep);

    // R10: asynchronous reset mid-run
    apply(1'b0, 12'h080, 12'h080, 12'h102, "R3 pre-reset");
    in_valid = 1'b0;
    #0.5 rst_n = 1'b0;
    #0.5;
    check("R10 async valid", {11'd0, out_valid}, 12'd0);
    check("R10 async result", result, 12'd0);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule